// File: doc/BRIEF.md
# Internal Interrupt Status and Enable Aggregator

This block collects the level interrupt lines of on-chip peripherals, 32 or 64 of them, into registered status words. It keeps one enable word set for each of two processor interrupt outputs. A processor output goes high when at least one source is both pending and enabled in that processor's set. Software reaches the status and enable words through a small word-addressed register port. Writes take effect at the clock edge on which they are presented. Reads are combinational.

Optionally, a contiguous run of internal bit positions can carry external interrupt lines instead of peripheral lines. The run is 4 or 6 bits wide and starts at a parameter-chosen index. Choosing a vector, ranking sources against each other and dispatching them are left to software.

The 64-source build stores its words in reversed group order, and enable and status words share the same reversal. Offset 0 holds sources 32 to 63 and offset 1 holds sources 0 to 31.

Top module: `irq_stat_mask_agg`

## Requirements
- R1: After reset every enable bit in both sets reads 0 and both processor outputs are 0.
- R2: A source is pending only when its status bit and the matching enable bit are both 1. A source that rises before clock edge k, with its enable already set, drives the processor output high after edge k+1 and not after edge k.
- R3: The register address is 3 bits. addr[2] picks the processor set (0 or 1). addr[1] picks the kind: 1 for enable, 0 for status. addr[0] is the word offset. In the 64-source build, source i is bit i mod 32 of offset (i/32) XOR 1, so offset 0 holds sources 32 to 63.
- R4: Status words use the same reversed offset order as enable words. Both processor sets read the same status contents.
- R5: Writes to status addresses have no effect. They change neither the status contents, the enable words nor the outputs.
- R6: An enable word reads back the whole 32-bit value last written to it. A 1 bit enables its source.
- R7: With cascading on, bits CASC_START to CASC_START+CASC_WIDTH-1 follow ext_irq, with ext_irq bit 0 at CASC_START. The peripheral inputs at those positions are ignored. By default the run covers sources 40 to 45, which are bits 8 to 13 of offset 0.
- R8: A write to one processor's enable words leaves the other processor's enable words and output unchanged.
- R9: Each processor output is registered. After an enable write commits on edge k, the output still shows the old value after edge k and the new value after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC | Peripheral interrupt levels, active high |
| ext_irq | input | CASC_WIDTH | External interrupt levels routed into the cascade run |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when 1, read when 0 |
| reg_addr | input | 3 | {processor set, kind, word offset} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word, combinational |
| irq_out | output | 2 | Per-processor interrupt request |

## Verification
A single source is enabled at offset 0 bit 0 while source 0 and then source 32 are raised. This tells a correct reversed mapping apart from a straight one, and it also fixes the two-edge latency of the output. A status pattern with sources 3, 33 and 63 set shows whether the status words reverse and whether bit 31 lands in the right place. In the cascade run, a peripheral line raised inside the run must stay invisible while an external pattern appears. Enabling a source only in the second processor's set shows that the two sets are kept apart, and clearing that enable shows the one-edge output delay.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
   localparam int WORD_W = 32;
   localparam int ADDR_W = 3;

   typedef enum logic {
      KIND_STATUS = 1'b0,
      KIND_MASK   = 1'b1
   } reg_kind_e;

   // Field order is part of the address decode: {cpu, kind, word}
   typedef struct packed {
      logic      cpu;
      reg_kind_e kind;
      logic      word;
   } reg_addr_t;

   // Offset <-> group mapping, self-inverse
   function automatic int offset_to_group(input int off, input int nwords);
      return off ^ (nwords - 1);
   endfunction
endpackage

// File: rtl/irqagg_src_merge.sv
`timescale 1ns/1ps
module irqagg_src_merge #(
   parameter int NUM_SRC    = 64,
   parameter bit CASC_EN    = 1'b1,
   parameter int CASC_START = 40,
   parameter int CASC_WIDTH = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    src_irq,
   input  logic [CASC_WIDTH-1:0] ext_irq,
   output logic [NUM_SRC-1:0]    status_q
);
   localparam int CASC_END = CASC_START + CASC_WIDTH;

   logic [NUM_SRC-1:0] merged;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (CASC_EN && (i >= CASC_START) && (i < CASC_END)) begin : g_ext
         logic periph_unused;
         assign periph_unused = src_irq[i];
         assign merged[i]     = ext_irq[i - CASC_START];
      end else begin : g_int
         assign merged[i] = src_irq[i];
      end
   end

   if (!CASC_EN) begin : g_no_casc
      logic ext_unused;
      assign ext_unused = ^ext_irq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= merged;
   end
endmodule

// File: rtl/irqagg_mask_bank.sv
`timescale 1ns/1ps
module irqagg_mask_bank
   import irqagg_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              word_sel,
   input  logic [WORD_W-1:0] wdata,
   output logic [NUM_SRC-1:0] mask_flat
);
   localparam int NW = NUM_SRC / WORD_W;

   logic [NUM_SRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_en) begin
         for (int g = 0; g < NW; g++) begin
            if (int'(word_sel) == offset_to_group(g, NW))
               mask_q[g*WORD_W +: WORD_W] <= wdata;
         end
      end
   end

   assign mask_flat = mask_q;
endmodule

// File: rtl/irqagg_read_mux.sv
`timescale 1ns/1ps
module irqagg_read_mux
   import irqagg_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int NUM_CPU = 2
) (
   input  reg_addr_t                        addr,
   input  logic [NUM_SRC-1:0]               status_q,
   input  logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask_all,
   output logic [WORD_W-1:0]                rdata
);
   localparam int NW = NUM_SRC / WORD_W;

   logic [NUM_SRC-1:0] sel_vec;
   int                 grp;

   always_comb begin
      sel_vec = (addr.kind == KIND_MASK) ? mask_all[addr.cpu] : status_q;
      grp     = offset_to_group(int'(addr.word), NW);
      rdata   = '0;
      if (int'(addr.word) < NW)
         rdata = sel_vec[grp*WORD_W +: WORD_W];
   end
endmodule

// File: rtl/irq_stat_mask_agg.sv
`timescale 1ns/1ps
module irq_stat_mask_agg
   import irqagg_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter bit CASC_EN    = 1'b1,
   parameter int CASC_START = 40,
   parameter int CASC_WIDTH = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    src_irq,
   input  logic [CASC_WIDTH-1:0] ext_irq,
   input  logic                  reg_cs,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [WORD_W-1:0]     reg_wdata,
   output logic [WORD_W-1:0]     reg_rdata,
   output logic [1:0]            irq_out
);
   localparam int NUM_CPU = 2;

   if (!(NUM_SRC == 32 || NUM_SRC == 64)) begin : g_bad_src
      $error("NUM_SRC must be 32 or 64");
   end
   if (!(CASC_WIDTH == 4 || CASC_WIDTH == 6)) begin : g_bad_cw
      $error("CASC_WIDTH must be 4 or 6");
   end
   if (CASC_START < 0 || CASC_START + CASC_WIDTH > NUM_SRC) begin : g_bad_cs
      $error("cascade run must fit inside the source vector");
   end

   reg_addr_t                       addr_s;
   logic [NUM_SRC-1:0]              status_q;
   logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_all;
   logic [NUM_CPU-1:0]              irq_q;

   assign addr_s = reg_addr_t'(reg_addr);

   irqagg_src_merge #(
      .NUM_SRC   (NUM_SRC),
      .CASC_EN   (CASC_EN),
      .CASC_START(CASC_START),
      .CASC_WIDTH(CASC_WIDTH)
   ) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_irq (src_irq),
      .ext_irq (ext_irq),
      .status_q(status_q)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic wr_hit;
      assign wr_hit = reg_cs && reg_we && (addr_s.kind == KIND_MASK)
                      && (int'(addr_s.cpu) == c);

      irqagg_mask_bank #(.NUM_SRC(NUM_SRC)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_hit),
         .word_sel (addr_s.word),
         .wdata    (reg_wdata),
         .mask_flat(mask_all[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q[c] <= 1'b0;
         else        irq_q[c] <= |(status_q & mask_all[c]);
      end
   end

   irqagg_read_mux #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_rd (
      .addr    (addr_s),
      .status_q(status_q),
      .mask_all(mask_all),
      .rdata   (reg_rdata)
   );

   assign irq_out = irq_q;
endmodule

// File: rtl/irqagg_chk.sv
`timescale 1ns/1ps
module irqagg_chk
   import irqagg_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter bit CASC_EN    = 1'b1,
   parameter int CASC_START = 40,
   parameter int CASC_WIDTH = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   reg_cs,
   input logic                   reg_we,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic [1:0]             irq_out,
   input logic [1:0][NUM_SRC-1:0] mask_all,
   input logic [NUM_SRC-1:0]     status_q,
   input logic [CASC_WIDTH-1:0]  ext_irq
);
   reg_addr_t a;
   assign a = reg_addr_t'(reg_addr);

   // R1
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_all == '0 && irq_out == 2'b00));

   // R2
   a_r2_unmasked_quiet0: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mask_all[0]) == '0) |-> !irq_out[0]);
   a_r2_unmasked_quiet1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mask_all[1]) == '0) |-> !irq_out[1]);
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_q) == '0) |-> (irq_out == 2'b00));

   // R5
   a_r5_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_cs && reg_we && a.kind == KIND_STATUS) |=> $stable(mask_all));

   // R8
   a_r8_cpu0_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_cs && reg_we && a.kind == KIND_MASK && !a.cpu) |=> $stable(mask_all[1]));
   a_r8_cpu1_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_cs && reg_we && a.kind == KIND_MASK && a.cpu) |=> $stable(mask_all[0]));

   // R7
   if (CASC_EN) begin : g_casc
      a_r7_cascade_follow: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (status_q[CASC_START +: CASC_WIDTH] == $past(ext_irq)));
   end else begin : g_nocasc
      logic ext_unused;
      assign ext_unused = ^ext_irq;
   end
endmodule

bind irq_stat_mask_agg irqagg_chk #(
   .NUM_SRC   (NUM_SRC),
   .CASC_EN   (CASC_EN),
   .CASC_START(CASC_START),
   .CASC_WIDTH(CASC_WIDTH)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_cs  (reg_cs),
   .reg_we  (reg_we),
   .reg_addr(reg_addr),
   .irq_out (irq_out),
   .mask_all(mask_all),
   .status_q(status_q),
   .ext_irq (ext_irq)
);

// File: tb/irq_stat_mask_agg_bench.sv
`timescale 1ns/1ps
module irq_stat_mask_agg_bench;
   localparam int NS = 64;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_irq = '0;
   logic [CW-1:0] ext_irq = '0;
   logic          reg_cs = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [1:0]    irq_out;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   irq_stat_mask_agg u_irq_stat_mask_agg (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .ext_irq(ext_irq),
      .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   function automatic logic [2:0] adr(input bit cpu, input bit is_mask, input bit word);
      return {cpu, is_mask, word};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input bit cpu, input bit is_mask, input bit word, input logic [31:0] d);
      @(negedge clk);
      reg_cs = 1'b1; reg_we = 1'b1; reg_addr = adr(cpu, is_mask, word); reg_wdata = d;
      @(negedge clk);
      reg_cs = 1'b0; reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input bit cpu, input bit is_mask, input bit word, output logic [31:0] d);
      reg_cs = 1'b1; reg_we = 1'b0; reg_addr = adr(cpu, is_mask, word);
      #1 d = reg_rdata;
      reg_cs = 1'b0;
   endtask

   task automatic clean();
      @(negedge clk);
      src_irq = '0; ext_irq = '0;
      for (int c = 0; c < 2; c++)
         for (int w = 0; w < 2; w++)
            wr(c[0], 1'b1, w[0], 32'h0);
      @(negedge clk); @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 outputs", {30'b0, irq_out}, 32'h0);
      for (int c = 0; c < 2; c++)
         for (int w = 0; w < 2; w++) begin
            rd(c[0], 1'b1, w[0], d);
            check("R1 enable word", d, 32'h0);
         end
   endtask

   task automatic t_order_latency();
      logic [31:0] d;
      clean();
      wr(1'b0, 1'b1, 1'b0, 32'h1);          // offset 0 bit 0 = source 32
      src_irq[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R3 source 0 not enabled by offset 0", {31'b0, irq_out[0]}, 32'h0);
      src_irq[32] = 1'b1;
      @(negedge clk);
      check("R2 one edge after source", {31'b0, irq_out[0]}, 32'h0);
      @(negedge clk);
      check("R2 two edges after source", {31'b0, irq_out[0]}, 32'h1);
      rd(1'b0, 1'b1, 1'b0, d); check("R6 readback offset 0", d, 32'h1);
      rd(1'b0, 1'b1, 1'b1, d); check("R6 readback offset 1", d, 32'h0);
   endtask

   task automatic t_status_order();
      logic [31:0] d;
      clean();
      src_irq[3] = 1'b1; src_irq[33] = 1'b1; src_irq[63] = 1'b1;
      @(negedge clk);
      rd(1'b0, 1'b0, 1'b0, d); check("R4 status offset 0", d, 32'h8000_0002);
      rd(1'b0, 1'b0, 1'b1, d); check("R4 status offset 1", d, 32'h0000_0008);
      rd(1'b1, 1'b0, 1'b1, d); check("R4 status via set 1", d, 32'h0000_0008);
   endtask

   task automatic t_status_write();
      logic [31:0] d;
      clean();
      src_irq[33] = 1'b1;
      wr(1'b0, 1'b1, 1'b0, 32'h2);
      @(negedge clk);
      check("R5 irq before status write", {31'b0, irq_out[0]}, 32'h1);
      wr(1'b0, 1'b0, 1'b0, 32'h0);
      wr(1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
      @(negedge clk);
      rd(1'b0, 1'b0, 1'b0, d); check("R5 status offset 0 kept", d, 32'h2);
      rd(1'b0, 1'b0, 1'b1, d); check("R5 status offset 1 kept", d, 32'h0);
      rd(1'b0, 1'b1, 1'b0, d); check("R5 enable kept", d, 32'h2);
      check("R5 irq kept", {31'b0, irq_out[0]}, 32'h1);
   endtask

   task automatic t_cascade();
      logic [31:0] d;
      clean();
      wr(1'b0, 1'b1, 1'b0, 32'h0000_3F00);  // sources 40..45
      src_irq[41] = 1'b1;
      @(negedge clk); @(negedge clk);
      rd(1'b0, 1'b0, 1'b0, d); check("R7 peripheral in run ignored", d, 32'h0);
      check("R7 no irq from peripheral in run", {31'b0, irq_out[0]}, 32'h0);
      ext_irq = 6'b000101;
      @(negedge clk); @(negedge clk);
      rd(1'b0, 1'b0, 1'b0, d); check("R7 external pattern", d, 32'h0000_0500);
      check("R7 irq from external", {31'b0, irq_out[0]}, 32'h1);
   endtask

   task automatic t_cpu_iso_latency();
      logic [31:0] d;
      clean();
      wr(1'b1, 1'b1, 1'b1, 32'h0000_0020);  // set 1, source 5
      src_irq[5] = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R8 only set 1 raised", {30'b0, irq_out}, 32'h2);
      rd(1'b0, 1'b1, 1'b1, d); check("R8 set 0 enable untouched", d, 32'h0);
      wr(1'b1, 1'b1, 1'b1, 32'h0);
      check("R9 output holds after commit edge", {31'b0, irq_out[1]}, 32'h1);
      @(negedge clk);
      check("R9 output drops one edge later", {31'b0, irq_out[1]}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order_latency();
      t_status_order();
      t_status_write();
      t_cascade();
      t_cpu_iso_latency();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule